// File: doc/BRIEF.md
# Overlay Pixel Formatter

This block sits between the overlay fetch path and the panel data pins. It takes 32-bit words of fetched pixel data on a valid/ready stream, splits each word into pixels according to a three-bit pixel-encoding code, widens every colour component to six bits, and drives an 18-bit panel bus. A two-bit output-mode code selects the bus arrangement. In parallel arrangements one whole pixel goes out per strobe, with red or blue in the top field. In serial arrangements the three components go out on three consecutive strobes, starting with red or with blue.

Palette-indexed pixels are not resolved here. Their 8-bit index is forwarded so that a later lookup stage can translate it. The encoding code is captured together with each accepted word. The output-mode code is captured when each pixel starts. Both codes may therefore change between words without corrupting data that is already inside the block.

Top module: `ovl_pixel_formatter`

## Requirements
- R1: After reset, `pix_strobe` and `fmt_err` are 0 and `in_ready` is 1.
- R2: With `out_mode` 00, each pixel produces one strobe carrying red in `pix_data[17:12]`, green in `[11:6]` and blue in `[5:0]`.
- R3: With `out_mode` 01, each pixel produces one strobe carrying blue in `pix_data[17:12]`, green in `[11:6]` and red in `[5:0]`.
- R4: With `out_mode` 10, each pixel produces three strobes on consecutive cycles carrying red, then green, then blue. Each component is in `pix_data[5:0]` and `pix_data[17:6]` is 0.
- R5: With `out_mode` 11, each pixel produces three consecutive strobes carrying blue, then green, then red, laid out as in R4.
- R6: With `bpp_mode` 100, a pixel byte holds red in bits [7:5], green in [4:2] and blue in [1:0]. Each field is widened to six bits by repeating its bits from the most significant end.
- R7: With `bpp_mode` 101, a 16-bit pixel holds red in [15:11], green in [10:5] and blue in [4:0]. Each 5-bit field becomes six bits by appending a copy of its top bit.
- R8: With `bpp_mode` 110, a 16-bit pixel holds red in [15:11], green in [10:6], blue in [5:1] and an intensity bit in [0]. Each six-bit component is the 5-bit field followed by the intensity bit.
- R9: With `bpp_mode` 111, each word is one pixel with red in [17:12], green in [11:6] and blue in [5:0]. Word bits [31:18] are ignored.
- R10: With `bpp_mode` 011, each byte is a palette index. It produces exactly one strobe per pixel, in every output mode, with the index in `pix_data[7:0]` and `pix_data[17:8]` at 0.
- R11: An 8-bit encoding gives four pixels per word and a 16-bit encoding gives two. Pixels leave in order starting from the least significant end of the word, and no pixel is lost or repeated.
- R12: `bpp_mode` codes 000, 001 and 010 take one pixel per word. That pixel is output as black (all data bits 0), with `fmt_err` at 1 on every strobe that belongs to it.
- R13: While input words are always offered, strobes come on every cycle with no gaps, in both parallel and serial modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bpp_mode | input | 3 | Pixel encoding code, captured with each accepted word |
| out_mode | input | 2 | Bus arrangement code, captured at the start of each pixel |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block takes the word at this clock edge |
| in_word | input | 32 | Packed pixel data |
| pix_strobe | output | 1 | `pix_data` holds a pixel or a component in this cycle |
| pix_data | output | 18 | Panel data |
| fmt_err | output | 1 | The current strobe belongs to an unsupported encoding |

## Verification
The bench sweeps all eight encoding codes against all four bus arrangements. It sends all-zero words, all-one words and pseudo-random words, and sometimes leaves gaps in `in_valid`. A wrong widening rule shows up on the all-one words as components that do not reach 63, or on random words as wrong low bits. Swapped channel order or the wrong serial sequence puts components in the wrong field or in the wrong strobe. Slot-order mistakes reverse the pixels inside a word. Palette indices split into three serial strobes would leave extra strobes that are not expected. Back-to-back runs check that a late `in_ready` does not open gaps at word boundaries. Unsupported codes must give black with the error flag on every strobe, including all three serial strobes.

// File: rtl/ovl_pix_pkg.sv
package ovl_pix_pkg;

   localparam int unsigned CH_W  = 6;
   localparam int unsigned PIX_W = 3 * CH_W;

   typedef logic [CH_W-1:0] chan_t;

   typedef struct packed {
      chan_t r;
      chan_t g;
      chan_t b;
   } rgb_t;

   typedef enum logic [2:0] {
      BPP_RSV0  = 3'b000,
      BPP_RSV1  = 3'b001,
      BPP_RSV2  = 3'b010,
      BPP_PAL8  = 3'b011,
      BPP_D332  = 3'b100,
      BPP_D565  = 3'b101,
      BPP_D5551 = 3'b110,
      BPP_U18   = 3'b111
   } bpp_e;

   // bit 1: serial, bit 0: blue leads
   typedef enum logic [1:0] {
      OUT_PAR_RGB = 2'b00,
      OUT_PAR_BGR = 2'b01,
      OUT_SER_RGB = 2'b10,
      OUT_SER_BGR = 2'b11
   } outm_e;

   // Widen a field of n bits, held left-aligned in src, by repeating it
   // from the most significant end until CH_W bits are filled.
   function automatic chan_t widen(input chan_t src, input int unsigned n);
      chan_t o;
      for (int unsigned i = 0; i < CH_W; i++) begin
         o[CH_W-1-i] = src[CH_W-1-(i % n)];
      end
      return o;
   endfunction

endpackage

// File: rtl/ovl_word_unpack.sv
module ovl_word_unpack
   import ovl_pix_pkg::*;
#(
   parameter int unsigned WORD_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [WORD_W-1:0]     in_word,
   input  logic [2:0]            bpp_mode,
   output logic                  px_avail,
   output logic [PIX_W-1:0]      px_raw,
   output bpp_e                  px_bpp,
   input  logic                  px_take
);

   localparam int unsigned LANE8_N  = WORD_W / 8;
   localparam int unsigned LANE16_N = WORD_W / 16;
   localparam int unsigned SLOT_W   = $clog2(LANE8_N);
   localparam int unsigned L16_W    = $clog2(LANE16_N);

   logic [WORD_W-1:0] wbuf;
   bpp_e              wmode;
   logic              wfull;
   logic [SLOT_W-1:0] slot;
   logic [SLOT_W-1:0] last_idx;
   logic              last_slot;

   logic [7:0]  lane8  [LANE8_N];
   logic [15:0] lane16 [LANE16_N];

   for (genvar i = 0; i < LANE8_N; i++) begin : g_lane8
      assign lane8[i] = wbuf[8*i +: 8];
   end
   for (genvar j = 0; j < LANE16_N; j++) begin : g_lane16
      assign lane16[j] = wbuf[16*j +: 16];
   end

   always_comb begin
      unique case (wmode)
         BPP_PAL8, BPP_D332:  last_idx = SLOT_W'(LANE8_N - 1);
         BPP_D565, BPP_D5551: last_idx = SLOT_W'(LANE16_N - 1);
         default:             last_idx = '0;
      endcase
   end

   assign last_slot = (slot == last_idx);

   always_comb begin
      unique case (wmode)
         BPP_PAL8, BPP_D332:  px_raw = {{(PIX_W-8){1'b0}}, lane8[slot]};
         BPP_D565, BPP_D5551: px_raw = {{(PIX_W-16){1'b0}}, lane16[slot[L16_W-1:0]]};
         BPP_U18:             px_raw = wbuf[PIX_W-1:0];
         default:             px_raw = '0;
      endcase
   end

   assign px_avail = wfull;
   assign px_bpp   = wmode;
   assign in_ready = !wfull || (px_take && last_slot);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbuf  <= '0;
         wmode <= BPP_RSV0;
         wfull <= 1'b0;
         slot  <= '0;
      end else if (in_valid && in_ready) begin
         wbuf  <= in_word;
         wmode <= bpp_e'(bpp_mode);
         wfull <= 1'b1;
         slot  <= '0;
      end else if (px_take) begin
         if (last_slot) begin
            wfull <= 1'b0;
         end else begin
            slot <= slot + 1'b1;
         end
      end
   end

   assert_accept_loads_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (wfull && slot == '0));

   assert_word_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wfull && !px_take) |=> $stable(wbuf));

   assert_slot_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wfull |-> (slot <= last_idx));

endmodule

// File: rtl/ovl_color_expand.sv
module ovl_color_expand
   import ovl_pix_pkg::*;
(
   input  logic [PIX_W-1:0] px_raw,
   input  bpp_e             px_bpp,
   output rgb_t             colour,
   output logic             is_index,
   output logic             bad_code
);

   always_comb begin
      colour   = '0;
      is_index = 1'b0;
      bad_code = 1'b0;
      unique case (px_bpp)
         BPP_PAL8: begin
            colour   = rgb_t'({{(PIX_W-8){1'b0}}, px_raw[7:0]});
            is_index = 1'b1;
         end
         BPP_D332: begin
            colour.r = widen({px_raw[7:5], {(CH_W-3){1'b0}}}, 3);
            colour.g = widen({px_raw[4:2], {(CH_W-3){1'b0}}}, 3);
            colour.b = widen({px_raw[1:0], {(CH_W-2){1'b0}}}, 2);
         end
         BPP_D565: begin
            colour.r = widen({px_raw[15:11], {(CH_W-5){1'b0}}}, 5);
            colour.g = px_raw[10:5];
            colour.b = widen({px_raw[4:0], {(CH_W-5){1'b0}}}, 5);
         end
         BPP_D5551: begin
            colour.r = {px_raw[15:11], px_raw[0]};
            colour.g = {px_raw[10:6],  px_raw[0]};
            colour.b = {px_raw[5:1],   px_raw[0]};
         end
         BPP_U18: begin
            colour = rgb_t'(px_raw);
         end
         default: begin
            bad_code = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/ovl_order_serializer.sv
module ovl_order_serializer
   import ovl_pix_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             px_avail,
   output logic             px_take,
   input  rgb_t             colour,
   input  logic             is_index,
   input  logic             bad_code,
   input  logic [1:0]       out_mode,
   output logic             pix_strobe,
   output logic [PIX_W-1:0] pix_data,
   output logic             fmt_err
);

   localparam int unsigned PAD_W = PIX_W - CH_W;

   logic [1:0] left;
   rgb_t       hold;
   logic       hold_bgr;
   logic       hold_err;

   assign px_take = px_avail && (left == 2'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left       <= 2'd0;
         hold       <= '0;
         hold_bgr   <= 1'b0;
         hold_err   <= 1'b0;
         pix_strobe <= 1'b0;
         pix_data   <= '0;
         fmt_err    <= 1'b0;
      end else if (left != 2'd0) begin
         pix_strobe <= 1'b1;
         fmt_err    <= hold_err;
         left       <= left - 2'd1;
         if (left == 2'd2) begin
            pix_data <= {{PAD_W{1'b0}}, hold.g};
         end else begin
            pix_data <= {{PAD_W{1'b0}}, hold_bgr ? hold.r : hold.b};
         end
      end else if (px_avail) begin
         pix_strobe <= 1'b1;
         fmt_err    <= bad_code;
         if (is_index || !out_mode[1]) begin
            pix_data <= (!is_index && out_mode[0]) ?
                        {colour.b, colour.g, colour.r} : colour;
         end else begin
            pix_data <= {{PAD_W{1'b0}}, out_mode[0] ? colour.b : colour.r};
            hold     <= colour;
            hold_bgr <= out_mode[0];
            hold_err <= bad_code;
            left     <= 2'd2;
         end
      end else begin
         pix_strobe <= 1'b0;
         fmt_err    <= 1'b0;
      end
   end

   assert_serial_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (left != 2'd0) |=> pix_strobe);

   assert_serial_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (left != 2'd0) |=> (pix_data[PIX_W-1:CH_W] == '0));

   assert_black_on_error_R12: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err |-> (pix_strobe && pix_data == '0));

   assert_left_range_R13: assert property (@(posedge clk) disable iff (!rst_n)
      left <= 2'd2);

endmodule

// File: rtl/ovl_pixel_formatter.sv
module ovl_pixel_formatter
   import ovl_pix_pkg::*;
#(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        bpp_mode,
   input  logic [1:0]        out_mode,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_word,
   output logic              pix_strobe,
   output logic [PIX_W-1:0]  pix_data,
   output logic              fmt_err
);

   if (WORD_W < 32 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word_w
      $error("WORD_W must be a power of two of at least 32");
   end

   logic             px_avail;
   logic             px_take;
   logic [PIX_W-1:0] px_raw;
   bpp_e             px_bpp;
   rgb_t             colour;
   logic             is_index;
   logic             bad_code;

   ovl_word_unpack #(.WORD_W(WORD_W)) u_unpack (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_word  (in_word),
      .bpp_mode (bpp_mode),
      .px_avail (px_avail),
      .px_raw   (px_raw),
      .px_bpp   (px_bpp),
      .px_take  (px_take)
   );

   ovl_color_expand u_expand (
      .px_raw   (px_raw),
      .px_bpp   (px_bpp),
      .colour   (colour),
      .is_index (is_index),
      .bad_code (bad_code)
   );

   ovl_order_serializer u_order (
      .clk        (clk),
      .rst_n      (rst_n),
      .px_avail   (px_avail),
      .px_take    (px_take),
      .colour     (colour),
      .is_index   (is_index),
      .bad_code   (bad_code),
      .out_mode   (out_mode),
      .pix_strobe (pix_strobe),
      .pix_data   (pix_data),
      .fmt_err    (fmt_err)
   );

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!pix_strobe && !fmt_err));

endmodule

// File: tb/ovl_pixel_formatter_test.sv
module ovl_pixel_formatter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bpp_mode = 3'd0;
   logic [1:0]  out_mode = 2'd0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_word = '0;
   logic        pix_strobe;
   logic [17:0] pix_data;
   logic        fmt_err;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 0;

   logic [18:0] exp_q[$];
   string       tag_q[$];

   bit win_on = 0;
   int win_n = 0;
   int win_first = 0;
   int win_last = 0;

   logic [31:0] lfsr = 32'h1D87_2C35;

   always #10 clk = ~clk;

   ovl_pixel_formatter uut (
      .clk(clk), .rst_n(rst_n), .bpp_mode(bpp_mode), .out_mode(out_mode),
      .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
      .pix_strobe(pix_strobe), .pix_data(pix_data), .fmt_err(fmt_err)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic string fmt_tag(input int b);
      case (b)
         3: return "R10";
         4: return "R6 R11";
         5: return "R7 R11";
         6: return "R8 R11";
         7: return "R9";
         default: return "R12";
      endcase
   endfunction

   function automatic string ord_tag(input int o);
      case (o)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic push(input int data, input bit err, input string tag);
      exp_q.push_back({err, 18'(data)});
      tag_q.push_back(tag);
   endtask

   task automatic add_pix(input int r, input int g, input int b, input bit err);
      string t;
      t = {fmt_tag(int'(bpp_mode)), " ", ord_tag(int'(out_mode))};
      case (out_mode)
         2'd0: push(r * 4096 + g * 64 + b, err, t);
         2'd1: push(b * 4096 + g * 64 + r, err, t);
         2'd2: begin push(r, err, t); push(g, err, t); push(b, err, t); end
         default: begin push(b, err, t); push(g, err, t); push(r, err, t); end
      endcase
   endtask

   task automatic expect_word(input logic [31:0] w);
      int p, r5, b5, i;
      case (bpp_mode)
         3'd3: for (int k = 0; k < 4; k++) push(int'((w >> (8 * k)) & 255), 1'b0, "R10 R11");
         3'd4: for (int k = 0; k < 4; k++) begin
            p = int'((w >> (8 * k)) & 255);
            add_pix(((p >> 5) & 7) * 9, ((p >> 2) & 7) * 9, (p & 3) * 21, 1'b0);
         end
         3'd5: for (int k = 0; k < 2; k++) begin
            p = int'((w >> (16 * k)) & 65535);
            r5 = (p >> 11) & 31;
            b5 = p & 31;
            add_pix(r5 * 2 + (r5 >> 4), (p >> 5) & 63, b5 * 2 + (b5 >> 4), 1'b0);
         end
         3'd6: for (int k = 0; k < 2; k++) begin
            p = int'((w >> (16 * k)) & 65535);
            i = p & 1;
            add_pix(((p >> 11) & 31) * 2 + i, ((p >> 6) & 31) * 2 + i,
                    ((p >> 1) & 31) * 2 + i, 1'b0);
         end
         3'd7: add_pix(int'((w >> 12) & 63), int'((w >> 6) & 63), int'(w & 63), 1'b0);
         default: add_pix(0, 0, 0, 1'b1);
      endcase
   endtask

   // Called at a negedge; leaves in_valid high at the following negedge.
   task automatic send_word(input logic [31:0] w);
      expect_word(w);
      in_word  = w;
      in_valid = 1'b1;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_cycle();
      in_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic drain(input string tag);
      in_valid = 1'b0;
      for (int n = 0; n < 200; n++) begin
         if (exp_q.size() == 0) break;
         @(negedge clk);
      end
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, tag, "pending pixels after drain",
            32'(exp_q.size()), 32'd0);
      exp_q.delete();
      tag_q.delete();
   endtask

   function automatic logic [31:0] next_rand(input logic [31:0] s);
      logic [31:0] x;
      x = s ^ (s << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && pix_strobe) begin
         if (win_on) begin
            if (win_n == 0) win_first = cyc;
            win_last = cyc;
            win_n++;
         end
         if (exp_q.size() == 0) begin
            check(1'b0, "R11", "strobe with nothing expected",
                  {13'd0, fmt_err, pix_data}, 32'd0);
         end else begin
            logic [18:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({fmt_err, pix_data} == e, t, "pixel output",
                  {13'd0, fmt_err, pix_data}, {13'd0, e});
         end
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         done = 1;
         failures++;
         checks++;
         $display("FAIL R13 watchdog expired actual=%0d expected=finished", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(pix_strobe == 1'b0, "R1", "strobe after reset", 32'(pix_strobe), 32'd0);
      check(fmt_err == 1'b0,    "R1", "error after reset",  32'(fmt_err), 32'd0);
      check(in_ready == 1'b1,   "R1", "ready after reset",  32'(in_ready), 32'd1);

      // Sweep every encoding against every bus arrangement.
      for (int b = 0; b < 8; b++) begin
         for (int o = 0; o < 4; o++) begin
            bpp_mode = 3'(b);
            out_mode = 2'(o);
            send_word(32'h0000_0000);
            send_word(32'hFFFF_FFFF);
            for (int k = 0; k < 6; k++) begin
               lfsr = next_rand(lfsr);
               send_word(lfsr);
               if (k % 2 == 1) idle_cycle();
            end
            drain({fmt_tag(b), " ", ord_tag(o)});
         end
      end

      // Back-to-back: parallel, one pixel per word (R13).
      bpp_mode = 3'd7;
      out_mode = 2'd0;
      win_n = 0;
      win_on = 1;
      for (int k = 0; k < 8; k++) begin
         lfsr = next_rand(lfsr);
         send_word(lfsr);
      end
      drain("R13");
      win_on = 0;
      check(win_n == 8, "R13", "parallel strobe count", 32'(win_n), 32'd8);
      check(win_last - win_first == 7, "R13", "parallel strobe span",
            32'(win_last - win_first), 32'd7);

      // Back-to-back: parallel, four pixels per word (R13, R11).
      bpp_mode = 3'd4;
      out_mode = 2'd1;
      win_n = 0;
      win_on = 1;
      for (int k = 0; k < 4; k++) begin
         lfsr = next_rand(lfsr);
         send_word(lfsr);
      end
      drain("R13");
      win_on = 0;
      check(win_n == 16, "R13", "packed strobe count", 32'(win_n), 32'd16);
      check(win_last - win_first == 15, "R13", "packed strobe span",
            32'(win_last - win_first), 32'd15);

      // Back-to-back: serial, two pixels per word (R13, R4).
      bpp_mode = 3'd5;
      out_mode = 2'd2;
      win_n = 0;
      win_on = 1;
      for (int k = 0; k < 4; k++) begin
         lfsr = next_rand(lfsr);
         send_word(lfsr);
      end
      drain("R13");
      win_on = 0;
      check(win_n == 24, "R13", "serial strobe count", 32'(win_n), 32'd24);
      check(win_last - win_first == 23, "R13", "serial strobe span",
            32'(win_last - win_first), 32'd23);

      // Upper word bits ignored in unpacked mode (R9).
      bpp_mode = 3'd7;
      out_mode = 2'd3;
      send_word(32'hFFFC_0000);
      send_word(32'hA5E0_0000 | 32'h0001_2345);
      drain("R9");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule